// File: doc/BRIEF.md
# Comparator Channel Measurement Controller

This block is the digital control and status logic for a bank of analog comparator channels. Each channel takes the raw digital output of an external comparator and its analog-ready indication. The block decides when a reading is taken and latches the result into status. It evaluates a selectable interrupt condition on every reading and keeps per-channel pending and mask bits. It also emits per-channel peripheral event pulses, and software can replace any comparator output with a fixed test value.

Software programs each channel through its own configuration word. The word holds a measurement mode (off, continuous, single shot on a software start, or single shot on a peripheral event), an interrupt condition, two event-output enables and a stay-powered bit. A channel without the stay-powered bit stays unpowered until something triggers it. It then waits a parameterised startup time before it measures, and it raises a startup interrupt when it becomes ready. Register access is a simple single-cycle write strobe with a combinational read.

Top module: `cmp_meas_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `evtOut` is zero.
- R2: In mode 2, writing 1 to control bit 2 (word 0) starts exactly one comparison on each such channel. Control bit 2 always reads 0. Later input changes do not alter the stored result.
- R3: A pulse on `periphEvent` starts one comparison on channels in mode 3, but only while control bit 1 (event input enable) is 1. Otherwise the pulse is ignored.
- R4: In mode 1, with the channel ready, the stored compare bit follows the comparator input after a two-flop synchronizer, with no software action.
- R5: Configuration bits [3:2] pick the interrupt condition that sets pending bit 2x on a reading: 0 when the new result is 1, 1 when it is 0, 2 when it differs from the stored result, 3 on every reading.
- R6: Status word 1 holds the compare result of channel x at bit 2x and its ready flag at bit 2x+1. Pending and mask words use the same positions, with bit 2x+1 as the startup interrupt.
- R7: Writing ones to word 3 sets mask bits and writing ones to word 4 clears them. Writing ones to word 6 clears pending bits. `irq` is the OR of pending AND mask.
- R8: A channel's comparator output is replaced by test word bit 8+x only when control bit 7 and test word bit x are both 1.
- R9: Configuration bit 4 emits a one-cycle `evtOut[x]` pulse on a reading of 0, and bit 5 does so on a reading of 1. No pulse occurs without a reading.
- R10: Without configuration bit 6 (stay powered), a triggered channel waits STARTUP_CYCLES cycles, then sets pending bit 2x+1 and becomes ready. A single-shot channel powers down after its reading. With bit 6 set, there is no wait and no startup interrupt.
- R11: The ready flag and any reading require `cmpReady[x]`. While it is low, the stored result is frozen.
- R12: With control bit 0 (global enable) at 0, or a channel in mode 0, no reading is taken, no event is emitted and the ready flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Word address for write and read |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Combinational read data |
| cmpRaw | input | NUM_CH | Raw comparator outputs (asynchronous) |
| cmpReady | input | NUM_CH | Analog-ready indication per channel |
| periphEvent | input | 1 | Incoming peripheral event pulse |
| evtOut | output | NUM_CH | Per-channel peripheral event pulses |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the startup path of a channel that is not kept powered. The bench sets up a single-shot channel, starts it, and samples pending and ready both before and after the startup window. That shows the startup interrupt, the delayed reading and the power-down that follows. A stay-powered channel in the same mode shares the same start, which shows that it measures at once and never raises a startup interrupt. Event pulses go to a scoreboard queue, so any extra or missing pulse from a shared start or a disabled event input is caught.

// File: rtl/acmp_pkg.sv
package acmp_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK   = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_MSET   = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_MCLR   = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_PEND   = 4'd5;
  localparam logic [ADDR_W-1:0] ADDR_PCLR   = 4'd6;
  localparam logic [ADDR_W-1:0] ADDR_TEST   = 4'd7;
  localparam int                CFG_BASE    = 8;

  localparam int CTRL_EN     = 0;
  localparam int CTRL_EVIN   = 1;
  localparam int CTRL_USTART = 2;
  localparam int CTRL_ESTART = 3;
  localparam int CTRL_TEST   = 7;
  localparam int TEST_VAL_LSB = 8;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_CONT  = 2'd1,
    MODE_USER  = 2'd2,
    MODE_EVENT = 2'd3
  } measMode_e;

  typedef enum logic [1:0] {
    INT_HIGH   = 2'd0,
    INT_LOW    = 2'd1,
    INT_TOGGLE = 2'd2,
    INT_DONE   = 2'd3
  } intCond_e;

  typedef struct packed {
    logic      stayOn;
    logic      evtHigh;
    logic      evtLow;
    intCond_e  intSel;
    measMode_e mode;
  } chanCfg_t;

  localparam int CFG_W = $bits(chanCfg_t);

  typedef struct packed {
    logic globalEn;
    logic userGo;
    logic eventGo;
  } acmpStrobe_t;
endpackage

// File: rtl/acmp_chan.sv
module acmp_chan
  import acmp_pkg::*;
#(
  parameter int STARTUP_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  acmpStrobe_t strobe,
  input  chanCfg_t    cfg,
  input  logic        testOverride,
  input  logic        testValue,
  input  logic        cmpRaw,
  input  logic        cmpReady,
  output logic [1:0]  statusPair,
  output logic [1:0]  intPair,
  output logic        evtOut
);
  localparam int CNT_W = (STARTUP_CYCLES > 1) ? $clog2(STARTUP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STARTUP_CYCLES - 1);

  logic [1:0]       syncQ;
  logic             trigQ, warmQ, compQ, evtQ;
  logic [CNT_W-1:0] cntQ;

  logic cmpEff, active, startReq, needPower, warmEff, measure, condHit, startupHit;

  // synchronized comparator output, optionally replaced by the test value
  assign cmpEff    = testOverride ? testValue : syncQ[1];
  assign active    = strobe.globalEn && (cfg.mode != MODE_OFF);
  assign startReq  = ((cfg.mode == MODE_USER)  && strobe.userGo) ||
                     ((cfg.mode == MODE_EVENT) && strobe.eventGo);
  assign needPower = (cfg.mode == MODE_CONT) || trigQ || startReq;
  assign warmEff   = cfg.stayOn || warmQ;
  assign measure   = active && warmEff && cmpReady &&
                     ((cfg.mode == MODE_CONT) || trigQ);
  assign startupHit = active && !cfg.stayOn && !warmQ && needPower &&
                      (cntQ == CNT_LAST);

  always_comb begin
    unique case (cfg.intSel)
      INT_HIGH:   condHit = cmpEff;
      INT_LOW:    condHit = !cmpEff;
      INT_TOGGLE: condHit = cmpEff != compQ;
      default:    condHit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      trigQ <= 1'b0;
      warmQ <= 1'b0;
      cntQ  <= '0;
      compQ <= 1'b0;
      evtQ  <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], cmpRaw};
      if (!active) begin
        trigQ <= 1'b0;
        warmQ <= 1'b0;
        cntQ  <= '0;
      end else begin
        if (measure && (cfg.mode != MODE_CONT)) begin
          trigQ <= startReq;
          if (!cfg.stayOn) warmQ <= 1'b0;
        end else if (startReq) begin
          trigQ <= 1'b1;
        end
        if (startupHit) begin
          warmQ <= 1'b1;
          cntQ  <= '0;
        end else if (!warmEff && needPower) begin
          cntQ <= cntQ + 1'b1;
        end
      end
      if (measure) compQ <= cmpEff;
      evtQ <= measure && ((cfg.evtHigh && cmpEff) || (cfg.evtLow && !cmpEff));
    end
  end

  assign statusPair = {active && warmEff && cmpReady, compQ};
  assign intPair    = {startupHit, measure && condHit};
  assign evtOut     = evtQ;
endmodule

// File: rtl/acmp_datapath.sv
module acmp_datapath
  import acmp_pkg::*;
#(
  parameter int NUM_CH         = 4,
  parameter int STARTUP_CYCLES = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  acmpStrobe_t           strobe,
  input  chanCfg_t [NUM_CH-1:0] cfg,
  input  logic [NUM_CH-1:0]     testOverride,
  input  logic [NUM_CH-1:0]     testValue,
  input  logic [NUM_CH-1:0]     cmpRaw,
  input  logic [NUM_CH-1:0]     cmpReady,
  output logic [2*NUM_CH-1:0]   statusBits,
  output logic [2*NUM_CH-1:0]   intSet,
  output logic [NUM_CH-1:0]     evtOut
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    acmp_chan #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_ch (
      .clk          (clk),
      .rstN         (rstN),
      .strobe       (strobe),
      .cfg          (cfg[g]),
      .testOverride (testOverride[g]),
      .testValue    (testValue[g]),
      .cmpRaw       (cmpRaw[g]),
      .cmpReady     (cmpReady[g]),
      .statusPair   (statusBits[2*g +: 2]),
      .intPair      (intSet[2*g +: 2]),
      .evtOut       (evtOut[g])
    );
  end
endmodule

// File: rtl/acmp_regs.sv
module acmp_regs
  import acmp_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  input  logic                  periphEvent,
  input  logic [2*NUM_CH-1:0]   statusBits,
  input  logic [2*NUM_CH-1:0]   intSet,
  output acmpStrobe_t           strobe,
  output chanCfg_t [NUM_CH-1:0] cfg,
  output logic [NUM_CH-1:0]     testOverride,
  output logic [NUM_CH-1:0]     testValue,
  output logic                  irq
);
  localparam int IW = 2 * NUM_CH;

  logic              globalEnQ, evtInQ, testModeQ, userGoQ, eventGoQ;
  logic [IW-1:0]     maskQ, pendQ;
  logic [NUM_CH-1:0] testEnQ, testValQ;
  chanCfg_t [NUM_CH-1:0] cfgQ;

  logic          wrCtrl;
  logic [IW-1:0] pendClr;

  assign wrCtrl  = wrEn && (addr == ADDR_CTRL);
  assign pendClr = (wrEn && (addr == ADDR_PCLR)) ? wrData[IW-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEnQ <= 1'b0;
      evtInQ    <= 1'b0;
      testModeQ <= 1'b0;
      userGoQ   <= 1'b0;
      eventGoQ  <= 1'b0;
      maskQ     <= '0;
      pendQ     <= '0;
      testEnQ   <= '0;
      testValQ  <= '0;
      cfgQ      <= '0;
    end else begin
      userGoQ  <= wrCtrl && wrData[CTRL_USTART];
      eventGoQ <= periphEvent && evtInQ && globalEnQ;
      if (wrCtrl) begin
        globalEnQ <= wrData[CTRL_EN];
        evtInQ    <= wrData[CTRL_EVIN];
        testModeQ <= wrData[CTRL_TEST];
      end
      if (wrEn && (addr == ADDR_MSET)) maskQ <= maskQ | wrData[IW-1:0];
      if (wrEn && (addr == ADDR_MCLR)) maskQ <= maskQ & ~wrData[IW-1:0];
      pendQ <= (pendQ & ~pendClr) | intSet;
      if (wrEn && (addr == ADDR_TEST)) begin
        testEnQ  <= wrData[NUM_CH-1:0];
        testValQ <= wrData[TEST_VAL_LSB +: NUM_CH];
      end
      for (int i = 0; i < NUM_CH; i++) begin
        if (wrEn && (addr == ADDR_W'(CFG_BASE + i))) cfgQ[i] <= chanCfg_t'(wrData[CFG_W-1:0]);
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CTRL: begin
        rdData[CTRL_EN]     = globalEnQ;
        rdData[CTRL_EVIN]   = evtInQ;
        rdData[CTRL_ESTART] = eventGoQ;
        rdData[CTRL_TEST]   = testModeQ;
      end
      ADDR_STATUS: rdData[IW-1:0] = statusBits;
      ADDR_MASK:   rdData[IW-1:0] = maskQ;
      ADDR_PEND:   rdData[IW-1:0] = pendQ;
      ADDR_TEST: begin
        rdData[NUM_CH-1:0]             = testEnQ;
        rdData[TEST_VAL_LSB +: NUM_CH] = testValQ;
      end
      default: begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (addr == ADDR_W'(CFG_BASE + i)) rdData[CFG_W-1:0] = cfgQ[i];
        end
      end
    endcase
  end

  assign strobe       = '{globalEn: globalEnQ, userGo: userGoQ, eventGo: eventGoQ};
  assign cfg          = cfgQ;
  assign testOverride = {NUM_CH{testModeQ}} & testEnQ;
  assign testValue    = testValQ;
  assign irq          = |(pendQ & maskQ);
endmodule

// File: rtl/cmp_meas_ctrl.sv
module cmp_meas_ctrl
  import acmp_pkg::*;
#(
  parameter int NUM_CH         = 4,
  parameter int STARTUP_CYCLES = 8,
  parameter int DATA_W         = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NUM_CH-1:0] cmpRaw,
  input  logic [NUM_CH-1:0] cmpReady,
  input  logic              periphEvent,
  output logic [NUM_CH-1:0] evtOut,
  output logic              irq
);
  acmpStrobe_t           strobe;
  chanCfg_t [NUM_CH-1:0] cfg;
  logic [NUM_CH-1:0]     testOverride, testValue;
  logic [2*NUM_CH-1:0]   statusBits, intSet;

  acmp_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (regWrEn),
    .addr         (regAddr),
    .wrData       (regWrData),
    .rdData       (regRdData),
    .periphEvent  (periphEvent),
    .statusBits   (statusBits),
    .intSet       (intSet),
    .strobe       (strobe),
    .cfg          (cfg),
    .testOverride (testOverride),
    .testValue    (testValue),
    .irq          (irq)
  );

  acmp_datapath #(.NUM_CH(NUM_CH), .STARTUP_CYCLES(STARTUP_CYCLES)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cfg          (cfg),
    .testOverride (testOverride),
    .testValue    (testValue),
    .cmpRaw       (cmpRaw),
    .cmpReady     (cmpReady),
    .statusBits   (statusBits),
    .intSet       (intSet),
    .evtOut       (evtOut)
  );
endmodule

// File: rtl/cmp_meas_ctrl_chk.sv
module cmp_meas_ctrl_chk
  import acmp_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [3:0]        regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic [NUM_CH-1:0] cmpReady,
  input logic [NUM_CH-1:0] evtOut,
  input logic              irq
);
  logic              enShadow;
  logic [NUM_CH-1:0] readyBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enShadow <= 1'b0;
    else if (regWrEn && regAddr == ADDR_CTRL) enShadow <= regWrData[CTRL_EN];
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) readyBits[i] = regRdData[2*i+1];
  end

  // R7: clearing every mask bit silences the request on the next cycle
  a_r7_mask_clear_quiets: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_MCLR && (&regWrData[2*NUM_CH-1:0])) |=> !irq);

  // R2: the software start bit never reads back as set
  a_r2_start_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_CTRL) |-> !regRdData[CTRL_USTART]);

  // R11: no ready flag without the analog ready input
  a_r11_ready_needs_analog: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_STATUS) |-> ((readyBits & ~cmpReady) == '0));

  // R12: a globally disabled block emits no event next cycle
  a_r12_disabled_no_event: assert property (@(posedge clk) disable iff (!rstN)
    !enShadow |=> (evtOut == '0));
endmodule

bind cmp_meas_ctrl cmp_meas_ctrl_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .cmpReady  (cmpReady),
  .evtOut    (evtOut),
  .irq       (irq)
);

// File: tb/cmp_meas_ctrl_test.sv
`timescale 1ns/100ps
module cmp_meas_ctrl_test;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [N-1:0] cmpRaw = '0;
  logic [N-1:0] cmpReady = '1;
  logic        periphEvent = 1'b0;
  logic [N-1:0] evtOut;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [N-1:0] expQ[$];

  always #2.5 clk = ~clk;

  cmp_meas_ctrl uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cmpRaw(cmpRaw),
    .cmpReady(cmpReady), .periphEvent(periphEvent), .evtOut(evtOut), .irq(irq)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(logic [3:0] a, logic [31:0] m, logic [31:0] e, string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    chk((regRdData & m) == e, tag, regRdData & m, e);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseEvent();
    @(negedge clk); periphEvent = 1'b1;
    @(negedge clk); periphEvent = 1'b0;
  endtask

  function automatic logic [31:0] cfgv(int mode, int sel, bit evL, bit evH, bit on);
    return 32'({on, evH, evL, 2'(sel), 2'(mode)});
  endfunction

  // scoreboard monitor: every event pulse must match the next expected item
  always @(negedge clk) begin
    if (rstN && evtOut != '0) begin
      if (expQ.size() == 0) chk(1'b0, "R9 unexpected event", 32'(evtOut), 0);
      else begin
        logic [N-1:0] e;
        e = expQ.pop_front();
        chk(evtOut == e, "R9 event pattern", 32'(evtOut), 32'(e));
      end
    end
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R1 reset state
    rdChk(4'd0, 32'hFFFF_FFFF, 0, "R1 ctrl");
    rdChk(4'd1, 32'hFFFF_FFFF, 0, "R1 status");
    rdChk(4'd5, 32'hFFFF_FFFF, 0, "R1 pend");
    rdChk(4'd2, 32'hFFFF_FFFF, 0, "R1 mask");
    chk(irq == 0 && evtOut == 0, "R1 irq/evt", {irq, 27'd0, evtOut}, 0);

    // R4/R6/R5 continuous, stay powered, condition high
    wr(4'd0, 32'h1);
    wr(4'd8, cfgv(1, 0, 0, 0, 1));
    cmpRaw[0] = 1'b1;
    idle(5);
    rdChk(4'd1, 32'h3, 32'h3, "R4 R6 compare and ready ch0");
    rdChk(4'd5, 32'h1, 32'h1, "R5 condition high pending");
    chk(irq == 0, "R7 masked irq low", 32'(irq), 0);
    wr(4'd3, 32'h1);
    chk(irq == 1, "R7 mask set raises irq", 32'(irq), 1);
    cmpRaw[0] = 1'b0;
    idle(5);
    rdChk(4'd1, 32'h1, 0, "R4 compare follows input");
    wr(4'd6, 32'h1);
    idle(2);
    rdChk(4'd5, 32'h1, 0, "R7 pending cleared");
    chk(irq == 0, "R7 irq after clear", 32'(irq), 0);
    wr(4'd4, 32'h1);

    // R5 condition low, then R12 channel off
    wr(4'd8, cfgv(1, 1, 0, 0, 1));
    idle(4);
    rdChk(4'd5, 32'h1, 32'h1, "R5 condition low pending");
    wr(4'd8, 0);
    wr(4'd6, 32'h1);
    cmpRaw[0] = 1'b1;
    idle(5);
    rdChk(4'd5, 32'h1, 0, "R12 off channel no reading");
    rdChk(4'd1, 32'h2, 0, "R12 off channel not ready");

    // R5 toggle condition on ch1
    wr(4'd9, cfgv(1, 2, 0, 0, 1));
    idle(5);
    rdChk(4'd5, 32'h4, 0, "R5 no toggle no pending");
    cmpRaw[1] = 1'b1;
    idle(5);
    rdChk(4'd5, 32'h4, 32'h4, "R5 toggle pending");
    wr(4'd6, 32'h4);
    idle(5);
    rdChk(4'd5, 32'h4, 0, "R5 steady input no re-pend");
    wr(4'd9, 0);

    // R2 user start on ch2 with high event output
    wr(4'd10, cfgv(2, 3, 0, 1, 1));
    cmpRaw[2] = 1'b1;
    idle(5);
    rdChk(4'd5, 32'h10, 0, "R2 no reading before start");
    rdChk(4'd1, 32'h30, 32'h20, "R2 ready but result unset");
    expQ.push_back(4'b0100);
    wr(4'd0, 32'h5);
    idle(4);
    rdChk(4'd1, 32'h10, 32'h10, "R2 single reading stored");
    rdChk(4'd5, 32'h10, 32'h10, "R5 done condition pending");
    rdChk(4'd0, 32'h4, 0, "R2 start bit reads zero");
    cmpRaw[2] = 1'b0;
    idle(5);
    rdChk(4'd1, 32'h10, 32'h10, "R2 result held after single shot");

    // R3 event start on ch3 with low event output
    wr(4'd11, cfgv(3, 3, 1, 0, 1));
    pulseEvent();
    idle(4);
    rdChk(4'd5, 32'h40, 0, "R3 event ignored while input disabled");
    wr(4'd0, 32'h3);
    expQ.push_back(4'b1000);
    pulseEvent();
    idle(4);
    rdChk(4'd5, 32'h40, 32'h40, "R3 event started reading");
    rdChk(4'd1, 32'hC0, 32'h80, "R3 R6 ch3 ready result low");

    // R8 test override on ch0
    wr(4'd8, cfgv(1, 0, 0, 0, 1));
    cmpRaw[0] = 1'b0;
    wr(4'd7, 32'h101);
    idle(5);
    rdChk(4'd1, 32'h1, 0, "R8 no override without global test bit");
    wr(4'd0, 32'h83);
    idle(3);
    rdChk(4'd1, 32'h1, 32'h1, "R8 override applied");
    wr(4'd7, 32'h0);
    idle(5);
    rdChk(4'd1, 32'h1, 0, "R8 override released");
    wr(4'd8, 0);

    // R10 startup wait on single-shot ch1, ch2 stays powered
    wr(4'd9, cfgv(2, 3, 0, 0, 0));
    cmpRaw[1] = 1'b1;
    wr(4'd6, 32'hFF);
    wr(4'd0, 32'h5);
    idle(3);
    rdChk(4'd5, 32'hC, 0, "R10 nothing during startup");
    idle(12);
    rdChk(4'd5, 32'hC, 32'hC, "R10 startup and reading pending");
    rdChk(4'd1, 32'hC, 32'h4, "R10 powered down after single shot");
    rdChk(4'd5, 32'h30, 32'h10, "R10 stay-powered no startup interrupt");

    // R10/R11 continuous ch1 without stay-powered
    wr(4'd9, cfgv(1, 0, 0, 0, 0));
    idle(3);
    rdChk(4'd1, 32'h8, 0, "R10 not ready during startup");
    idle(12);
    rdChk(4'd1, 32'h8, 32'h8, "R10 ready after startup");
    cmpReady[1] = 1'b0;
    idle(2);
    rdChk(4'd1, 32'h8, 0, "R11 ready follows analog ready");
    cmpRaw[1] = 1'b0;
    idle(5);
    rdChk(4'd1, 32'h4, 32'h4, "R11 result frozen");
    cmpReady[1] = 1'b1;
    idle(5);
    rdChk(4'd1, 32'h4, 0, "R4 result resumes tracking");

    // R12 global disable, R7 final mask/pending handling
    wr(4'd0, 32'h0);
    idle(2);
    rdChk(4'd1, 32'hAA, 0, "R12 no ready when disabled");
    wr(4'd3, 32'hFF);
    chk(irq == 1, "R7 irq with all masks", 32'(irq), 1);
    wr(4'd4, 32'hFF);
    chk(irq == 0, "R7 irq after mask clear", 32'(irq), 0);
    wr(4'd6, 32'hFF);
    rdChk(4'd5, 32'hFF, 0, "R7 pending all cleared");
    idle(3);
    chk(expQ.size() == 0, "R9 all expected events seen", 32'(expQ.size()), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule